// File: doc/BRIEF.md
# Load/Store Effective Address Generator

This block sits in the address stage of a load/store pipe. It takes a 32-bit load/store instruction word, the values already read for its base and index registers, and the access size. From these it produces the memory effective address, an optional base-register update, a load/store flag and the number of the data register. The register file and the memory access are outside the block.

Two addressing forms are decoded, chosen by one form bit. The indexed form adds an index register to the base, optionally scaled by the access size. The short form adds a 5-bit signed immediate. The short immediate sits in a different field for stores than for loads, because stores carry their source register where loads carry the immediate. Each form can also leave the base unchanged or update it. The update is either post-increment style (the old base addresses memory) or pre-increment style (the new base addresses memory). All results are registered and appear one cycle after a valid strobe.

Top module: `lsu_ea_gen`

## Requirements
- R1: While reset is asserted, and right after it, `outValid` and `wbEn` are 0 and `effAddr`, `wbValue`, `wbReg`, `dataReg` and `isStore` are 0.
- R2: Results appear on the outputs in the cycle after an `inValid` cycle, with `outValid` 1; a cycle without `inValid` gives `outValid` 0 in the following cycle. Back-to-back strobes give back-to-back results.
- R3: Instruction bit 12 = 0 selects the indexed form. With bit 5 = 0 and bit 13 = 0, `effAddr` = base + index (modulo 2^32) and `wbEn` = 0. The base register number is bits 25:21 and the index register number is bits 20:16.
- R4: In the indexed form, bit 13 = 1 shifts the index left by `accSize` (0 byte, 1 halfword, 2 word) before the add. An `accSize` of 3 shifts by 2.
- R5: In the indexed form, bit 5 = 1 gives `effAddr` = old base, `wbEn` = 1 and `wbValue` = base + (possibly scaled) index.
- R6: Bit 12 = 1 selects the short form. The minor opcode is bits 9:6: values 0 to 7 are loads, which take the immediate sign-extended from bits 20:16; values 8 to 15 are stores, which take it from bits 4:0. With bit 5 = 0, `effAddr` = base + immediate and `wbEn` = 0, whatever bit 13 holds.
- R7: In the short form, bit 5 = 1, bit 13 = 0 and a nonzero immediate give a post-update: `effAddr` = old base, `wbEn` = 1, `wbValue` = base + immediate.
- R8: In the short form, bit 5 = 1 and bit 13 = 1 give a pre-update: `effAddr` = `wbValue` = base + immediate, with `wbEn` = 1.
- R9: In the short form, bit 5 = 1, bit 13 = 0 and a zero immediate give no update: `wbEn` = 0 and `effAddr` = base.
- R10: `isStore` is 1 only for a short-form minor opcode of 8 or more; the indexed form always reports a load. `dataReg` is bits 20:16 when `isStore` is 1 and bits 4:0 otherwise. `wbReg` is bits 25:21.
- R11: A base or index register number of 0 supplies the value 0 regardless of `baseVal` or `indexVal`, and no writeback is raised when the base register number is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| inValid | input | 1 | Instruction and operands valid this cycle |
| instr | input | 32 | Load/store instruction word |
| baseVal | input | XLEN | Value read from the base register |
| indexVal | input | XLEN | Value read from the index register |
| accSize | input | SIZE_W | Access size code: 0 byte, 1 halfword, 2 word |
| outValid | output | 1 | Registered results valid |
| effAddr | output | XLEN | Memory effective address |
| wbEn | output | 1 | Base register update enable |
| wbReg | output | 5 | Base register number to update |
| wbValue | output | XLEN | New base value |
| isStore | output | 1 | 1 for a store, 0 for a load |
| dataReg | output | 5 | Load target or store source register number |

## Verification
The hardest case to reach is a short-form store whose update bit is set, whose scale bit is clear and whose low immediate field is zero, while the load-immediate field is nonzero. Only a decoder that picks the immediate from the field the opcode names will treat this as no update. The stimulus table builds this word on purpose. It also builds the mirror cases, where the field a load would use holds a value that would change the address. These go with zero-numbered base and index registers whose operand inputs carry nonzero values, and with a size code of 3 under scaling. In every case a wrong field choice shows up on the address or writeback ports.

// File: rtl/lsu_ea_pkg.sv
package lsu_ea_pkg;

  localparam int REG_W = 5;
  localparam int IMM_W = 5;

  typedef enum logic [1:0] {
    UPD_NONE,
    UPD_AFTER,
    UPD_BEFORE
  } updMode_e;

  // Strobes from decode to the datapath
  typedef struct packed {
    logic useImm;      // short form: displacement is the immediate
    logic immLow;      // immediate taken from the low field (stores)
    logic scaleEn;     // shift the index by the access size
    logic modeAfter;   // address = old base, base updated
    logic modeBefore;  // address = updated base
    logic storeOp;     // store operation
  } eaStrobes_t;

endpackage

// File: rtl/lsu_ea_decode.sv
module lsu_ea_decode
  import lsu_ea_pkg::*;
(
  input  logic             formBit,
  input  logic             scaleBit,
  input  logic             updBit,
  input  logic             opHigh,
  input  logic [REG_W-1:0] midField,
  input  logic [REG_W-1:0] lowField,
  output eaStrobes_t       strobes
);

  logic             shortForm;
  logic [IMM_W-1:0] immField;
  updMode_e         mode;

  assign shortForm = formBit;
  assign immField  = opHigh ? lowField : midField;

  always_comb begin
    mode = UPD_NONE;
    if (!shortForm) begin
      if (updBit) mode = UPD_AFTER;
    end else if (updBit) begin
      if (scaleBit)             mode = UPD_BEFORE;
      else if (immField != '0)  mode = UPD_AFTER;
    end
  end

  always_comb begin
    strobes            = '0;
    strobes.useImm     = shortForm;
    strobes.immLow     = opHigh;
    strobes.scaleEn    = !shortForm && scaleBit;
    strobes.modeAfter  = (mode == UPD_AFTER);
    strobes.modeBefore = (mode == UPD_BEFORE);
    strobes.storeOp    = shortForm && opHigh;
  end

endmodule

// File: rtl/lsu_ea_datapath.sv
module lsu_ea_datapath
  import lsu_ea_pkg::*;
#(
  parameter int XLEN      = 32,
  parameter int MAX_SCALE = 2,
  parameter int SIZE_W    = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              inValid,
  input  eaStrobes_t        strobes,
  input  logic [REG_W-1:0]  baseReg,
  input  logic [REG_W-1:0]  midField,
  input  logic [REG_W-1:0]  lowField,
  input  logic [SIZE_W-1:0] accSize,
  input  logic [XLEN-1:0]   baseVal,
  input  logic [XLEN-1:0]   indexVal,
  output logic              outValid,
  output logic [XLEN-1:0]   effAddr,
  output logic              wbEn,
  output logic [REG_W-1:0]  wbReg,
  output logic [XLEN-1:0]   wbValue,
  output logic              isStore,
  output logic [REG_W-1:0]  dataReg
);

  localparam int NUM_SCALE = MAX_SCALE + 1;

  logic [XLEN-1:0]   baseEff;
  logic [XLEN-1:0]   idxEff;
  logic [XLEN-1:0]   scaledCand [NUM_SCALE];
  logic [XLEN-1:0]   scaledIdx;
  logic [SIZE_W-1:0] shiftSel;
  logic [IMM_W-1:0]  immRaw;
  logic [XLEN-1:0]   immExt;
  logic [XLEN-1:0]   disp;
  logic [XLEN-1:0]   sum;
  logic [XLEN-1:0]   nextAddr;
  logic              nextWbEn;

  // register 0 always reads as zero
  assign baseEff = (baseReg  == '0) ? '0 : baseVal;
  assign idxEff  = (midField == '0) ? '0 : indexVal;

  generate
    for (genvar k = 0; k < NUM_SCALE; k++) begin : g_scale
      assign scaledCand[k] = idxEff << k;
    end
  endgenerate

  assign shiftSel = (int'(accSize) > MAX_SCALE) ? SIZE_W'(MAX_SCALE) : accSize;

  always_comb begin
    scaledIdx = idxEff;
    for (int k = 0; k < NUM_SCALE; k++) begin
      if (shiftSel == SIZE_W'(k)) scaledIdx = scaledCand[k];
    end
  end

  assign immRaw = strobes.immLow ? lowField : midField;
  assign immExt = {{(XLEN-IMM_W){immRaw[IMM_W-1]}}, immRaw};

  always_comb begin
    if (strobes.useImm)       disp = immExt;
    else if (strobes.scaleEn) disp = scaledIdx;
    else                      disp = idxEff;
  end

  assign sum      = baseEff + disp;
  assign nextAddr = strobes.modeAfter ? baseEff : sum;
  assign nextWbEn = (strobes.modeAfter || strobes.modeBefore) && (baseReg != '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      outValid <= 1'b0;
      effAddr  <= '0;
      wbEn     <= 1'b0;
      wbReg    <= '0;
      wbValue  <= '0;
      isStore  <= 1'b0;
      dataReg  <= '0;
    end else begin
      outValid <= inValid;
      if (inValid) begin
        effAddr <= nextAddr;
        wbEn    <= nextWbEn;
        wbReg   <= baseReg;
        wbValue <= sum;
        isStore <= strobes.storeOp;
        dataReg <= strobes.storeOp ? midField : lowField;
      end
    end
  end

  // R2
  vld_track_chk: assert property (@(posedge clk) disable iff (!rst_n)
    inValid |=> outValid);

  // R2
  vld_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !inValid |=> !outValid);

  // R11
  wb_zero_reg_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wbEn |-> (wbReg != '0));

  // R7
  after_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (inValid && strobes.modeAfter) |=> (effAddr == $past(baseEff)));

  // R8
  before_wb_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (inValid && strobes.modeBefore && baseReg != '0) |=> (wbEn && wbValue == effAddr));

  // R3
  no_upd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (inValid && !strobes.modeAfter && !strobes.modeBefore) |=> !wbEn);

  // R9
  mode_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({strobes.modeAfter, strobes.modeBefore}));

endmodule

// File: rtl/lsu_ea_gen.sv
module lsu_ea_gen
  import lsu_ea_pkg::*;
#(
  parameter int XLEN      = 32,
  parameter int MAX_SCALE = 2,
  parameter int SIZE_W    = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              inValid,
  input  logic [31:0]       instr,
  input  logic [XLEN-1:0]   baseVal,
  input  logic [XLEN-1:0]   indexVal,
  input  logic [SIZE_W-1:0] accSize,
  output logic              outValid,
  output logic [XLEN-1:0]   effAddr,
  output logic              wbEn,
  output logic [REG_W-1:0]  wbReg,
  output logic [XLEN-1:0]   wbValue,
  output logic              isStore,
  output logic [REG_W-1:0]  dataReg
);

  eaStrobes_t       strobes;
  logic [REG_W-1:0] baseReg;
  logic [REG_W-1:0] midField;
  logic [REG_W-1:0] lowField;
  logic             unusedInstrBits;

  assign baseReg  = instr[25:21];
  assign midField = instr[20:16];
  assign lowField = instr[4:0];
  assign unusedInstrBits = ^{instr[31:26], instr[15:14], instr[11:10], instr[8:6]};

  lsu_ea_decode u_decode (
    .formBit  (instr[12]),
    .scaleBit (instr[13]),
    .updBit   (instr[5]),
    .opHigh   (instr[9]),
    .midField (midField),
    .lowField (lowField),
    .strobes  (strobes)
  );

  lsu_ea_datapath #(
    .XLEN      (XLEN),
    .MAX_SCALE (MAX_SCALE),
    .SIZE_W    (SIZE_W)
  ) u_datapath (
    .clk      (clk),
    .rst_n    (rst_n),
    .inValid  (inValid),
    .strobes  (strobes),
    .baseReg  (baseReg),
    .midField (midField),
    .lowField (lowField),
    .accSize  (accSize),
    .baseVal  (baseVal),
    .indexVal (indexVal),
    .outValid (outValid),
    .effAddr  (effAddr),
    .wbEn     (wbEn),
    .wbReg    (wbReg),
    .wbValue  (wbValue),
    .isStore  (isStore),
    .dataReg  (dataReg)
  );

endmodule

// File: tb/lsu_ea_gen_bench.sv
module lsu_ea_gen_bench;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        inValid = 1'b0;
  logic [31:0] instr = '0;
  logic [31:0] baseVal = '0;
  logic [31:0] indexVal = '0;
  logic [1:0]  accSize = '0;
  logic        outValid;
  logic [31:0] effAddr;
  logic        wbEn;
  logic [4:0]  wbReg;
  logic [31:0] wbValue;
  logic        isStore;
  logic [4:0]  dataReg;

  int applied = 0;
  int miscompares = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  lsu_ea_gen u_lsu_ea_gen (
    .clk(clk), .rst_n(rst_n), .inValid(inValid), .instr(instr),
    .baseVal(baseVal), .indexVal(indexVal), .accSize(accSize),
    .outValid(outValid), .effAddr(effAddr), .wbEn(wbEn), .wbReg(wbReg),
    .wbValue(wbValue), .isStore(isStore), .dataReg(dataReg)
  );

  // fields: base[25:21] mid[20:16] scale[13] form[12] minor[9:6] upd[5] low[4:0]
  function automatic logic [31:0] mk(input logic [4:0] b, input logic [4:0] mid,
      input logic [4:0] lo, input logic [3:0] minor, input logic s,
      input logic f, input logic m);
    logic [31:0] w;
    w = '0;
    w[25:21] = b; w[20:16] = mid; w[13] = s; w[12] = f;
    w[9:6] = minor; w[5] = m; w[4:0] = lo;
    return w;
  endfunction

  typedef struct packed {
    logic [31:0] ins;
    logic [31:0] base;
    logic [31:0] idx;
    logic [1:0]  size;
    logic [31:0] ea;
    logic        we;
    logic [31:0] wb;
    logic        st;
    logic [4:0]  dreg;
    logic [3:0]  req;
  } vec_t;

  localparam int NV = 22;
  localparam vec_t VECS [NV] = '{
    '{mk(3,4,7,2,0,0,0),  32'h1000, 32'h10, 2'd2, 32'h1010, 1'b0, 32'h0,    1'b0, 5'd7,  4'd3},  // R3
    '{mk(3,4,7,0,1,0,0),  32'h1000, 32'h10, 2'd0, 32'h1010, 1'b0, 32'h0,    1'b0, 5'd7,  4'd4},  // R4 byte
    '{mk(3,4,7,1,1,0,0),  32'h1000, 32'h10, 2'd1, 32'h1020, 1'b0, 32'h0,    1'b0, 5'd7,  4'd4},  // R4 half
    '{mk(3,4,7,2,1,0,0),  32'h1000, 32'h10, 2'd2, 32'h1040, 1'b0, 32'h0,    1'b0, 5'd7,  4'd4},  // R4 word
    '{mk(3,4,7,2,1,0,0),  32'h1000, 32'h10, 2'd3, 32'h1040, 1'b0, 32'h0,    1'b0, 5'd7,  4'd4},  // R4 size 3
    '{mk(3,4,7,2,0,0,1),  32'h1000, 32'h10, 2'd2, 32'h1000, 1'b1, 32'h1010, 1'b0, 5'd7,  4'd5},  // R5
    '{mk(3,4,7,2,1,0,1),  32'h1000, 32'h10, 2'd2, 32'h1000, 1'b1, 32'h1040, 1'b0, 5'd7,  4'd5},  // R5 scaled
    '{mk(3,4,7,2,0,0,0),  32'h1000, 32'hFFFFFFF0, 2'd2, 32'h0FF0, 1'b0, 32'h0, 1'b0, 5'd7, 4'd3}, // R3 negative
    '{mk(3,28,9,2,0,1,0), 32'h1000, 32'h10, 2'd2, 32'h0FFC, 1'b0, 32'h0,    1'b0, 5'd9,  4'd6},  // R6 load -4
    '{mk(3,11,6,10,0,1,0),32'h1000, 32'h10, 2'd2, 32'h1006, 1'b0, 32'h0,    1'b1, 5'd11, 4'd6},  // R6 store
    '{mk(3,2,1,2,1,1,0),  32'h1000, 32'h10, 2'd2, 32'h1002, 1'b0, 32'h0,    1'b0, 5'd1,  4'd6},  // R6 scale bit ignored
    '{mk(3,8,2,2,0,1,1),  32'h1000, 32'h10, 2'd2, 32'h1000, 1'b1, 32'h1008, 1'b0, 5'd2,  4'd7},  // R7 load
    '{mk(3,5,31,9,0,1,1), 32'h1000, 32'h10, 2'd2, 32'h1000, 1'b1, 32'h0FFF, 1'b1, 5'd5,  4'd7},  // R7 store
    '{mk(3,16,4,2,1,1,1), 32'h1000, 32'h10, 2'd2, 32'h0FF0, 1'b1, 32'h0FF0, 1'b0, 5'd4,  4'd8},  // R8 load
    '{mk(3,6,3,10,1,1,1), 32'h1000, 32'h10, 2'd2, 32'h1003, 1'b1, 32'h1003, 1'b1, 5'd6,  4'd8},  // R8 store
    '{mk(3,0,4,2,0,1,1),  32'h1000, 32'h10, 2'd2, 32'h1000, 1'b0, 32'h0,    1'b0, 5'd4,  4'd9},  // R9 load
    '{mk(3,7,0,8,0,1,1),  32'h1000, 32'h10, 2'd2, 32'h1000, 1'b0, 32'h0,    1'b1, 5'd7,  4'd9},  // R9 store, mid nonzero
    '{mk(3,4,3,10,0,0,0), 32'h1000, 32'h10, 2'd2, 32'h1010, 1'b0, 32'h0,    1'b0, 5'd3,  4'd10}, // R10 indexed high opcode
    '{mk(0,4,7,2,0,0,1),  32'h1000, 32'h10, 2'd2, 32'h0,    1'b0, 32'h0,    1'b0, 5'd7,  4'd11}, // R11 base reg 0
    '{mk(3,0,7,2,0,0,0),  32'h1000, 32'h10, 2'd2, 32'h1000, 1'b0, 32'h0,    1'b0, 5'd7,  4'd11}, // R11 index reg 0
    '{mk(0,4,1,2,1,1,1),  32'h1000, 32'h10, 2'd2, 32'h4,    1'b0, 32'h0,    1'b0, 5'd1,  4'd11}, // R11 pre-update on reg 0
    '{mk(3,4,7,2,0,0,0),  32'hFFFFFFFC, 32'h8, 2'd2, 32'h4, 1'b0, 32'h0,    1'b0, 5'd7,  4'd3}   // R3 wrap
  };

  task automatic check(input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    applied++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic drive(input vec_t v);
    inValid  = 1'b1;
    instr    = v.ins;
    baseVal  = v.base;
    indexVal = v.idx;
    accSize  = v.size;
  endtask

  task automatic checkVec(input vec_t v);
    string tag;
    tag = $sformatf("R%0d", v.req);
    check(tag, "outValid", {31'b0, outValid}, 32'd1);
    check(tag, "effAddr", effAddr, v.ea);
    check(tag, "wbEn", {31'b0, wbEn}, {31'b0, v.we});
    if (v.we) begin
      check(tag, "wbValue", wbValue, v.wb);
      check(tag, "wbReg", {27'b0, wbReg}, {27'b0, v.ins[25:21]});
    end
    check(tag, "isStore", {31'b0, isStore}, {31'b0, v.st});
    check(tag, "dataReg", {27'b0, dataReg}, {27'b0, v.dreg});
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("== %0d vectors applied, %0d miscompares ==", applied, miscompares);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    miscompares++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    check("R1", "outValid", {31'b0, outValid}, 32'd0);
    check("R1", "wbEn", {31'b0, wbEn}, 32'd0);
    check("R1", "effAddr", effAddr, 32'd0);
    check("R1", "dataReg", {27'b0, dataReg}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1", "outValid after release", {31'b0, outValid}, 32'd0);

    // table walk, one strobe then one idle cycle
    for (int i = 0; i < NV; i++) begin
      drive(VECS[i]);
      @(negedge clk);
      checkVec(VECS[i]);
      inValid = 1'b0;
      @(negedge clk);
      // R2: no strobe, no valid
      check("R2", "outValid idle", {31'b0, outValid}, 32'd0);
    end

    // R2: back-to-back strobes
    drive(VECS[5]);
    @(negedge clk);
    checkVec(VECS[5]);
    drive(VECS[13]);
    @(negedge clk);
    checkVec(VECS[13]);
    drive(VECS[16]);
    @(negedge clk);
    checkVec(VECS[16]);
    inValid = 1'b0;
    @(negedge clk);
    check("R2", "outValid after burst", {31'b0, outValid}, 32'd0);

    // R1: reset while a result is held
    drive(VECS[11]);
    @(negedge clk);
    inValid = 1'b0;
    rst_n = 1'b0;
    #1;
    check("R1", "outValid in reset", {31'b0, outValid}, 32'd0);
    check("R1", "wbEn in reset", {31'b0, wbEn}, 32'd0);
    check("R1", "wbValue in reset", wbValue, 32'd0);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1", "outValid after re-reset", {31'b0, outValid}, 32'd0);

    finish_run();
  end

endmodule